// File: doc/BRIEF.md
# Delayed-Branch Next-PC Unit

This block picks the address of the next instruction for a 32-bit RISC pipeline whose control transfers take effect one instruction late. For every issued instruction it is handed the instruction's address and a 3-bit transfer kind. It also receives the signed 26-bit word displacement, a register-held target, the condition flag, and the saved exception address and status word. In the same cycle it returns the address to fetch next. When the instruction is a call, it also returns a link-register write. When the instruction returns from an exception, it also returns a status-restore strobe.

A taken conditional branch or any jump does not redirect at once. The unit first lets the instruction that follows it (the delay slot) proceed to PC+4, and records the destination in a one-entry pending register. When the next instruction issues, the unit sends control to the recorded destination. A return from exception takes effect at once: there is no slot, and the saved address and saved status are used directly. A transfer instruction that sits in a delay slot is illegal. The unit flags it and discards every effect of it. Calls write PC+8 so that the return skips the slot.

Top module: `nxpc_unit`

## Requirements
- R1: Transfer kind 1 (branch on flag set) is taken only when `flag` is 1. Kind 2 (branch on flag clear) is taken only when `flag` is 0. A taken branch sets `slot_pending` in the following cycle.
- R2: For kinds 1 to 4, the destination is `pc` plus the sign-extended `offset` times 4, computed modulo 2^32. This destination is delivered as `next_pc` of the delay-slot instruction.
- R3: After a taken branch or a jump, the transfer's own `next_pc` is `pc`+4. Exactly one further issued instruction then receives the destination as its `next_pc`, and `slot_pending` drops after that instruction.
- R4: Kinds 4 (direct call) and 6 (register call) raise `link_we` in the same cycle, with `link_idx` = 9 and `link_val` = `pc`+8 modulo 2^32. In all other cycles `link_we` is 0 and `link_val` is 0.
- R5: Kinds 5 (register jump) and 6 use `reg_target` unchanged as the destination.
- R6: Kind 7 (exception return) sets `next_pc` to `epc` in the same cycle. It also raises `sr_load` with `sr_val` = `esr`, and it leaves no delay slot. In all other cycles `sr_load` is 0 and `sr_val` is 0.
- R7: An untaken branch yields `next_pc` = `pc`+4 and leaves `slot_pending` at 0.
- R8: An issued instruction of a nonzero kind that sits in a delay slot raises `slot_fault`. It causes no link write, no status restore and no new pending destination, and its `next_pc` is still the recorded destination.
- R9: Kind 0 (no transfer), issued outside a slot, yields `next_pc` = `pc`+4 and no strobes.
- R10: While `issue` is 0, `next_pc` equals `pc`, all strobes are 0, and `slot_pending` keeps its value.
- R11: Reset clears `slot_pending`, even when a destination was recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| issue | input | 1 | An instruction is issued this cycle |
| xfer_kind | input | 3 | Transfer kind: 0 none, 1 branch on flag, 2 branch on no flag, 3 jump, 4 call, 5 register jump, 6 register call, 7 exception return |
| pc | input | 32 | Address of the issued instruction |
| offset | input | 26 | Signed word displacement for direct transfers |
| reg_target | input | 32 | Register operand used as a destination |
| flag | input | 1 | Condition flag |
| epc | input | 32 | Saved exception address |
| esr | input | 32 | Saved exception status word |
| next_pc | output | 32 | Address of the next instruction |
| link_we | output | 1 | Link register write strobe |
| link_idx | output | 5 | Register index written by the link write |
| link_val | output | 32 | Return address written to the link register |
| sr_load | output | 1 | Status register restore strobe |
| sr_val | output | 32 | Status word to restore |
| slot_pending | output | 1 | The next issued instruction is a delay slot |
| slot_fault | output | 1 | A transfer was issued inside a delay slot |

## Verification
`next_pc`, the link write, the status restore and `slot_fault` are combinational from the issued instruction and the pending register, so they are due in the same cycle as `issue`. `slot_pending` changes at the rising edge that closes the transfer's cycle, so it is due one cycle later. The bench drives each instruction on a falling edge and samples the same-cycle results 1 ns later. It compares `slot_pending` against its model before the model applies that instruction, so the flag is always checked in the cycle after the transfer that set or cleared it.

// File: rtl/nxpc_pkg.sv
package nxpc_pkg;

   typedef enum logic [2:0] {
      XK_NONE         = 3'd0,
      XK_BR_SET       = 3'd1,
      XK_BR_CLR       = 3'd2,
      XK_JMP          = 3'd3,
      XK_JMP_LINK     = 3'd4,
      XK_JMP_REG      = 3'd5,
      XK_JMP_REG_LINK = 3'd6,
      XK_EXC_RET      = 3'd7
   } xfer_kind_e;

   typedef struct packed {
      logic is_xfer;   // any control transfer
      logic redirect;  // deferred redirect after one slot
      logic use_reg;   // destination from register operand
      logic link;      // write return address
      logic exc_ret;   // immediate return from exception
   } xfer_ctl_t;

endpackage

// File: rtl/nxpc_decode.sv
module nxpc_decode
   import nxpc_pkg::*;
(
   input  xfer_kind_e kind,
   input  logic       flag,
   output xfer_ctl_t  ctl
);

   always_comb begin
      ctl = '0;
      ctl.is_xfer = (kind != XK_NONE);
      unique case (kind)
         XK_BR_SET:       ctl.redirect = flag;
         XK_BR_CLR:       ctl.redirect = ~flag;
         XK_JMP:          ctl.redirect = 1'b1;
         XK_JMP_LINK: begin
            ctl.redirect = 1'b1;
            ctl.link     = 1'b1;
         end
         XK_JMP_REG: begin
            ctl.redirect = 1'b1;
            ctl.use_reg  = 1'b1;
         end
         XK_JMP_REG_LINK: begin
            ctl.redirect = 1'b1;
            ctl.use_reg  = 1'b1;
            ctl.link     = 1'b1;
         end
         XK_EXC_RET:      ctl.exc_ret = 1'b1;
         default:         ctl.redirect = 1'b0;
      endcase
   end

endmodule

// File: rtl/nxpc_target.sv
module nxpc_target #(
   parameter int XLEN       = 32,
   parameter int OFF_W      = 26,
   parameter int INSN_BYTES = 4,
   parameter bit ALIGN_REG  = 1'b0
) (
   input  logic [XLEN-1:0]  pc,
   input  logic [OFF_W-1:0] offset,
   input  logic [XLEN-1:0]  reg_target,
   input  logic             use_reg,
   output logic [XLEN-1:0]  target
);

   localparam int SHIFT = $clog2(INSN_BYTES);
   localparam int EXT_W = XLEN - OFF_W;

   logic [XLEN-1:0] disp;
   logic [XLEN-1:0] direct_tgt;
   logic [XLEN-1:0] reg_tgt;

   assign disp       = {{EXT_W{offset[OFF_W-1]}}, offset} << SHIFT;
   assign direct_tgt = pc + disp;

   generate
      if (ALIGN_REG && SHIFT > 0) begin : g_reg_aligned
         assign reg_tgt = {reg_target[XLEN-1:SHIFT], {SHIFT{1'b0}}};
      end else begin : g_reg_raw
         assign reg_tgt = reg_target;
      end
   endgenerate

   assign target = use_reg ? reg_tgt : direct_tgt;

endmodule

// File: rtl/nxpc_slot.sv
module nxpc_slot #(
   parameter int XLEN = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            arm,
   input  logic            consume,
   input  logic [XLEN-1:0] arm_target,
   output logic            pending,
   output logic [XLEN-1:0] target
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pending <= 1'b0;
         target  <= '0;
      end else if (arm) begin
         pending <= 1'b1;
         target  <= arm_target;
      end else if (consume) begin
         pending <= 1'b0;
      end
   end

endmodule

// File: rtl/nxpc_unit.sv
module nxpc_unit
   import nxpc_pkg::*;
#(
   parameter int XLEN       = 32,
   parameter int OFF_W      = 26,
   parameter int SR_W       = 32,
   parameter int RIDX_W     = 5,
   parameter int LINK_REG   = 9,
   parameter int INSN_BYTES = 4,
   parameter bit ALIGN_REG  = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              issue,
   input  logic [2:0]        xfer_kind,
   input  logic [XLEN-1:0]   pc,
   input  logic [OFF_W-1:0]  offset,
   input  logic [XLEN-1:0]   reg_target,
   input  logic              flag,
   input  logic [XLEN-1:0]   epc,
   input  logic [SR_W-1:0]   esr,
   output logic [XLEN-1:0]   next_pc,
   output logic              link_we,
   output logic [RIDX_W-1:0] link_idx,
   output logic [XLEN-1:0]   link_val,
   output logic              sr_load,
   output logic [SR_W-1:0]   sr_val,
   output logic              slot_pending,
   output logic              slot_fault
);

   localparam logic [XLEN-1:0] SEQ_STEP  = XLEN'(INSN_BYTES);
   localparam logic [XLEN-1:0] LINK_STEP = XLEN'(2 * INSN_BYTES);

   generate
      if (OFF_W >= XLEN) begin : g_bad_off
         $error("nxpc_unit: OFF_W must be narrower than XLEN");
      end
      if (LINK_REG >= (1 << RIDX_W)) begin : g_bad_link
         $error("nxpc_unit: LINK_REG does not fit in RIDX_W");
      end
      if (INSN_BYTES < 1 || (INSN_BYTES & (INSN_BYTES - 1)) != 0) begin : g_bad_insn
         $error("nxpc_unit: INSN_BYTES must be a power of two");
      end
   endgenerate

   xfer_ctl_t       ctl;
   logic [XLEN-1:0] xfer_tgt;
   logic [XLEN-1:0] held_tgt;
   logic            in_slot;
   logic            act;

   nxpc_decode u_decode (
      .kind (xfer_kind_e'(xfer_kind)),
      .flag (flag),
      .ctl  (ctl)
   );

   nxpc_target #(
      .XLEN       (XLEN),
      .OFF_W      (OFF_W),
      .INSN_BYTES (INSN_BYTES),
      .ALIGN_REG  (ALIGN_REG)
   ) u_target (
      .pc         (pc),
      .offset     (offset),
      .reg_target (reg_target),
      .use_reg    (ctl.use_reg),
      .target     (xfer_tgt)
   );

   assign in_slot = issue & slot_pending;
   assign act     = issue & ~slot_pending;

   nxpc_slot #(
      .XLEN (XLEN)
   ) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .arm        (act & ctl.redirect),
      .consume    (in_slot),
      .arm_target (xfer_tgt),
      .pending    (slot_pending),
      .target     (held_tgt)
   );

   always_comb begin
      if (!issue)
         next_pc = pc;
      else if (in_slot)
         next_pc = held_tgt;
      else if (ctl.exc_ret)
         next_pc = epc;
      else
         next_pc = pc + SEQ_STEP;
   end

   assign slot_fault = in_slot & ctl.is_xfer;
   assign link_we    = act & ctl.link;
   assign link_idx   = RIDX_W'(LINK_REG);
   assign link_val   = link_we ? (pc + LINK_STEP) : '0;
   assign sr_load    = act & ctl.exc_ret;
   assign sr_val     = sr_load ? esr : '0;

endmodule

// File: rtl/nxpc_unit_chk.sv
module nxpc_unit_chk
   import nxpc_pkg::*;
#(
   parameter int XLEN       = 32,
   parameter int SR_W       = 32,
   parameter int RIDX_W     = 5,
   parameter int LINK_REG   = 9,
   parameter int INSN_BYTES = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              issue,
   input logic [2:0]        xfer_kind,
   input logic [XLEN-1:0]   pc,
   input logic              flag,
   input logic [XLEN-1:0]   epc,
   input logic [SR_W-1:0]   esr,
   input logic [XLEN-1:0]   next_pc,
   input logic              link_we,
   input logic [RIDX_W-1:0] link_idx,
   input logic [XLEN-1:0]   link_val,
   input logic              sr_load,
   input logic [SR_W-1:0]   sr_val,
   input logic              slot_pending,
   input logic              slot_fault
);

   localparam logic [XLEN-1:0] STEP1 = XLEN'(INSN_BYTES);
   localparam logic [XLEN-1:0] STEP2 = XLEN'(2 * INSN_BYTES);

   logic br_taken;
   logic br_skip;
   assign br_taken = (xfer_kind == XK_BR_SET && flag) || (xfer_kind == XK_BR_CLR && !flag);
   assign br_skip  = (xfer_kind == XK_BR_SET && !flag) || (xfer_kind == XK_BR_CLR && flag);

   assert_taken_arms_R1: assert property (@(posedge clk) disable iff (!rst_n)
      issue && !slot_pending && br_taken |=> slot_pending);

   assert_single_slot_R3: assert property (@(posedge clk) disable iff (!rst_n)
      issue && slot_pending |=> !slot_pending);

   assert_link_value_R4: assert property (@(posedge clk) disable iff (!rst_n)
      link_we |-> (link_idx == RIDX_W'(LINK_REG)) && (link_val == pc + STEP2));

   assert_exc_return_R6: assert property (@(posedge clk) disable iff (!rst_n)
      sr_load |-> (next_pc == epc) && (sr_val == esr));

   assert_exc_no_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
      sr_load |=> !slot_pending);

   assert_untaken_seq_R7: assert property (@(posedge clk) disable iff (!rst_n)
      issue && !slot_pending && br_skip |-> next_pc == pc + STEP1);

   assert_untaken_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      issue && !slot_pending && br_skip |=> !slot_pending);

   assert_fault_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      slot_fault |-> !link_we && !sr_load);

   assert_idle_outputs_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !issue |-> (next_pc == pc) && !link_we && !sr_load && !slot_fault);

   assert_idle_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !issue |=> $stable(slot_pending));

endmodule

bind nxpc_unit nxpc_unit_chk #(
   .XLEN       (XLEN),
   .SR_W       (SR_W),
   .RIDX_W     (RIDX_W),
   .LINK_REG   (LINK_REG),
   .INSN_BYTES (INSN_BYTES)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .issue        (issue),
   .xfer_kind    (xfer_kind),
   .pc           (pc),
   .flag         (flag),
   .epc          (epc),
   .esr          (esr),
   .next_pc      (next_pc),
   .link_we      (link_we),
   .link_idx     (link_idx),
   .link_val     (link_val),
   .sr_load      (sr_load),
   .sr_val       (sr_val),
   .slot_pending (slot_pending),
   .slot_fault   (slot_fault)
);

// File: tb/nxpc_unit_bench.sv
`timescale 1ns/1ps
module nxpc_unit_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        issue = 1'b0;
   logic [2:0]  xfer_kind = '0;
   logic [31:0] pc = '0;
   logic [25:0] offset = '0;
   logic [31:0] reg_target = '0;
   logic        flag = 1'b0;
   logic [31:0] epc = '0;
   logic [31:0] esr = '0;
   logic [31:0] next_pc;
   logic        link_we;
   logic [4:0]  link_idx;
   logic [31:0] link_val;
   logic        sr_load;
   logic [31:0] sr_val;
   logic        slot_pending;
   logic        slot_fault;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   bit          m_pend = 1'b0;
   logic [31:0] m_tgt  = '0;

   always #2.5 clk = ~clk;

   nxpc_unit u_nxpc_unit (
      .clk          (clk),
      .rst_n        (rst_n),
      .issue        (issue),
      .xfer_kind    (xfer_kind),
      .pc           (pc),
      .offset       (offset),
      .reg_target   (reg_target),
      .flag         (flag),
      .epc          (epc),
      .esr          (esr),
      .next_pc      (next_pc),
      .link_we      (link_we),
      .link_idx     (link_idx),
      .link_val     (link_val),
      .sr_load      (sr_load),
      .sr_val       (sr_val),
      .slot_pending (slot_pending),
      .slot_fault   (slot_fault)
   );

   function automatic logic [31:0] direct_dest(logic [31:0] p, logic [25:0] o);
      return p + ({{6{o[25]}}, o} << 2);
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic step(bit iss, logic [2:0] k, logic [31:0] p, logic [25:0] o,
                       logic [31:0] r, bit f, logic [31:0] ep, logic [31:0] es);
      logic [31:0] e_next;
      bit e_lwe, e_srl, e_fault, arm;
      logic [31:0] arm_tgt;
      string tag;
      @(negedge clk);
      issue = iss; xfer_kind = k; pc = p; offset = o;
      reg_target = r; flag = f; epc = ep; esr = es;
      #1;
      check(m_pend ? "R3 pending flag" : "R7 pending flag", {31'd0, slot_pending}, {31'd0, m_pend});
      e_lwe = 0; e_srl = 0; e_fault = 0; arm = 0; arm_tgt = '0;
      if (!iss) begin
         e_next = p; tag = "R10";
      end else if (m_pend) begin
         e_next = m_tgt; e_fault = (k != 3'd0);
         tag = e_fault ? "R8" : "R3";
      end else begin
         e_next = p + 32'd4; tag = "R9";
         case (k)
            3'd1: begin arm = f;  arm_tgt = direct_dest(p, o); tag = f ? "R1" : "R7"; end
            3'd2: begin arm = !f; arm_tgt = direct_dest(p, o); tag = !f ? "R1" : "R7"; end
            3'd3: begin arm = 1;  arm_tgt = direct_dest(p, o); tag = "R2"; end
            3'd4: begin arm = 1;  arm_tgt = direct_dest(p, o); e_lwe = 1; tag = "R4"; end
            3'd5: begin arm = 1;  arm_tgt = r; tag = "R5"; end
            3'd6: begin arm = 1;  arm_tgt = r; e_lwe = 1; tag = "R4"; end
            3'd7: begin e_next = ep; e_srl = 1; tag = "R6"; end
            default: ;
         endcase
      end
      check({tag, " next_pc"}, next_pc, e_next);
      check("R4 link_we", {31'd0, link_we}, {31'd0, e_lwe});
      check("R4 link_val", link_val, e_lwe ? p + 32'd8 : 32'd0);
      if (e_lwe) check("R4 link_idx", {27'd0, link_idx}, 32'd9);
      check("R6 sr_load", {31'd0, sr_load}, {31'd0, e_srl});
      check("R6 sr_val", sr_val, e_srl ? es : 32'd0);
      check("R8 slot_fault", {31'd0, slot_fault}, {31'd0, e_fault});
      if (iss && m_pend) m_pend = 0;
      else if (arm) begin m_pend = 1; m_tgt = arm_tgt; end
   endtask

   initial begin
      void'($urandom(32'h5EED_0042));
      repeat (3) @(posedge clk);
      #1;
      check("R11 reset pending", {31'd0, slot_pending}, 32'd0);
      check("R11 reset next_pc", next_pc, 32'd0);
      rst_n = 1'b1;

      // R2: most negative displacement, then the slot
      step(1, 3'd3, 32'h1000_0000, 26'h200_0000, 0, 0, 0, 0);
      step(1, 3'd0, 32'h1000_0004, 0, 0, 0, 0, 0);
      // R2: displacement of -1 word from a taken flag-set branch (R1)
      step(1, 3'd1, 32'h0000_0100, 26'h3FF_FFFF, 0, 1, 0, 0);
      step(1, 3'd0, 32'h0000_0104, 0, 0, 0, 0, 0);
      // R7: flag-clear branch with flag set is untaken
      step(1, 3'd2, 32'h0000_0200, 26'h10, 0, 1, 0, 0);
      // R4: call near address wrap
      step(1, 3'd4, 32'hFFFF_FFFC, 26'h4, 0, 0, 0, 0);
      // R10: idle cycles inside the slot window keep it pending
      step(0, 3'd5, 32'h1234_5678, 0, 0, 0, 0, 0);
      step(0, 3'd7, 32'h0000_0040, 0, 0, 0, 32'hAA, 32'hBB);
      // R8: register call inside slot is ignored
      step(1, 3'd6, 32'h0000_0000, 0, 32'hDEAD_BEE0, 0, 0, 0);
      // R6: exception return
      step(1, 3'd7, 32'h0000_0300, 0, 0, 0, 32'h0000_2000, 32'h8000_0001);
      // R5: register jump, then exception return inside slot (R8)
      step(1, 3'd5, 32'h0000_0400, 0, 32'h0BAD_CAF3, 0, 0, 0);
      step(1, 3'd7, 32'h0000_0404, 0, 0, 0, 32'h5555_0000, 32'h7);
      // R11: reset with a pending destination
      step(1, 3'd3, 32'h0000_0500, 26'h8, 0, 0, 0, 0);
      @(negedge clk);
      issue = 0; rst_n = 1'b0;
      #1;
      check("R11 reset clears pending", {31'd0, slot_pending}, 32'd0);
      m_pend = 0;
      @(negedge clk);
      rst_n = 1'b1;

      for (int i = 0; i < 3000; i++) begin
         bit iss;
         iss = ($urandom_range(0, 9) != 0);
         step(iss, 3'($urandom_range(0, 7)), {$urandom, 2'b00} , 26'($urandom),
              $urandom, 1'($urandom), $urandom, $urandom);
      end

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #200000;
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule